// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind an ARINC 429 receive front end that has already assembled complete 32-bit words. For every word it receives, the block decides whether the word is kept. Kept words are queued in a receive FIFO, and the host drains that FIFO one word at a time. The decision uses two tests, and each test can be switched on or off.

The first test compares ARINC bits 9 and 10 (the source/destination pair) with two configured bits. The second test looks up the 8-bit label in a 16-entry label table. The table is written and read back through a separate access mode.

The FIFO reports data-ready, half-full and full. Each flag also has an active-low pin equivalent, so it can be wired straight to an interrupt or handshake line.

Top module: `a429_rx_filter`

## Requirements
- R1: With `cfg_sd_en`=1, a valid word is stored only if `word_in[8]` (ARINC bit 9) equals `cfg_sd9` and `word_in[9]` (ARINC bit 10) equals `cfg_sd10`.
- R2: With `cfg_sd_en`=0, the values of `word_in[9:8]` have no effect on whether a word is stored.
- R3: With `cfg_lbl_en`=1, a valid word is stored only if its label `word_in[7:0]` (ARINC bits 1 to 8) equals one of the 16 table entries. With `cfg_lbl_en`=0, any label passes.
- R4: While `cfg_tab_mode`=1, each `tab_load` pulse writes `tab_wdata` to the next entry in the order 0, 1, ..., 15, and each `tab_rd` pulse advances the read pointer. `tab_rdata` always shows the entry at the read pointer. Both pointers return to 0 while `cfg_tab_mode`=0, and `tab_load` has no effect in that mode.
- R5: `rx_rdy` is 1 whenever the FIFO holds at least one word and returns to 0 once the last word has been read. `rx_rdy_n` is its inverse.
- R6: `rx_half` is 1 when the FIFO holds 16 or more words and 0 when it holds fewer. `rx_half_n` is its inverse.
- R7: `rx_full` is 1 when the FIFO holds 32 words. `rx_full_n` is its inverse.
- R8: A word that passes both tests while the FIFO is full is discarded, and the stored words and their order stay unchanged.
- R9: When both tests are enabled, a word is stored only if it passes both. A rejected word leaves the FIFO contents and all flags unchanged.
- R10: Words leave the FIFO in arrival order. `rx_data` shows the oldest word, and `rx_pop` removes it. A pop while the FIFO is empty is ignored.
- R11: After reset the FIFO is empty (`rx_rdy`=0, `rx_half`=0, `rx_full`=0, with the active-low pins at 1) and every table entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A complete word is present on `word_in` this cycle |
| word_in | input | 32 | Received word; bit 0 is ARINC bit 1 |
| cfg_sd_en | input | 1 | Enable the bit 9/10 test |
| cfg_sd9 | input | 1 | Required value of ARINC bit 9 |
| cfg_sd10 | input | 1 | Required value of ARINC bit 10 |
| cfg_lbl_en | input | 1 | Enable the label-table test |
| cfg_tab_mode | input | 1 | 1 = label table access mode, 0 = normal |
| tab_load | input | 1 | Write strobe for the next table entry |
| tab_wdata | input | 8 | Label to write |
| tab_rd | input | 1 | Advance the table read pointer |
| tab_rdata | output | 8 | Table entry at the read pointer |
| rx_pop | input | 1 | Remove the oldest FIFO word |
| rx_data | output | 32 | Oldest FIFO word |
| rx_rdy | output | 1 | FIFO not empty |
| rx_rdy_n | output | 1 | Inverse of `rx_rdy` |
| rx_half | output | 1 | FIFO holds 16 or more words |
| rx_half_n | output | 1 | Inverse of `rx_half` |
| rx_full | output | 1 | FIFO holds 32 words |
| rx_full_n | output | 1 | Inverse of `rx_full` |

## Verification
The bit 9/10 test is swept over all 32 combinations of enable, the two configured bits and the two word bits. This shows whether the comparison uses the right bit positions and the right polarity, and whether disabling the test really removes it.

All 256 labels are then sent against a table loaded with 16 scattered labels. This separates exact matching from partial or aliased matching.

A second sweep enables both tests together, to show whether they are combined as an AND.

A fill to 33 words followed by a full drain probes the half-full threshold on both sides, the full flag, and whether an excess word is dropped or overwrites stored data. It also probes arrival order. A pop on an empty FIFO and a normal-mode table write check that inputs outside their mode have no effect.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;

  localparam int A_WORD_W = 32;
  localparam int A_LBL_W  = 8;
  localparam int A_SD9    = 8;   // ARINC bit 9
  localparam int A_SD10   = 9;   // ARINC bit 10

  // Label field: ARINC bits 1..8
  function automatic logic [A_LBL_W-1:0] f_label(input logic [A_WORD_W-1:0] w);
    return w[A_LBL_W-1:0];
  endfunction

  // Source/destination test; passes when disabled
  function automatic logic f_sd_ok(input logic [A_WORD_W-1:0] w,
                                   input logic en, input logic b9, input logic b10);
    return !en || ((w[A_SD9] == b9) && (w[A_SD10] == b10));
  endfunction

endpackage

// File: rtl/a429_label_table.sv
module a429_label_table #(
  parameter int LBL_W = 8,
  parameter int LBL_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access,
  input  logic             load,
  input  logic [LBL_W-1:0] wdata,
  input  logic             rd,
  output logic [LBL_W-1:0] rdata,
  input  logic [LBL_W-1:0] label_in,
  output logic             hit
);
  localparam int PW = (LBL_N > 1) ? $clog2(LBL_N) : 1;

  function automatic logic [PW-1:0] f_step(input logic [PW-1:0] p);
    return (p == PW'(LBL_N - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [LBL_W-1:0] entry [LBL_N];
  logic [PW-1:0]    wptr, rptr;
  logic [LBL_N-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (!access) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (load) wptr <= f_step(wptr);
      if (rd)   rptr <= f_step(rptr);
    end
  end

  for (genvar i = 0; i < LBL_N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[i] <= '0;
      else if (access && load && (wptr == PW'(i)))
        entry[i] <= wdata;
    end
    assign match[i] = (entry[i] == label_in);
  end

  assign hit   = |match;
  assign rdata = entry[rptr];
endmodule

// File: rtl/a429_word_gate.sv
module a429_word_gate
  import a429_filt_pkg::*;
(
  input  logic                valid,
  input  logic [A_WORD_W-1:0] word,
  input  logic                sd_en,
  input  logic                sd9,
  input  logic                sd10,
  input  logic                lbl_en,
  input  logic                lbl_hit,
  output logic                sd_ok,
  output logic                lbl_ok,
  output logic                accept
);
  assign sd_ok  = f_sd_ok(word, sd_en, sd9, sd10);
  assign lbl_ok = !lbl_en || lbl_hit;
  assign accept = valid && sd_ok && lbl_ok;
endmodule

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         push_ok,
  output logic         pop_ok,
  output logic         not_empty,
  output logic         half,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  function automatic logic [AW-1:0] f_adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign push_ok = push && (cnt != CW'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= f_adv(wp);
      if (pop_ok)  rp <= f_adv(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (push_ok && (wp == AW'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata     = mem[rp];
  assign not_empty = (cnt != '0);
  assign half      = (cnt >= CW'(HALF));
  assign full      = (cnt == CW'(DEPTH));
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_filt_pkg::*;
#(
  parameter int LBL_N = 16,
  parameter int DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_valid,
  input  logic [A_WORD_W-1:0] word_in,
  input  logic                cfg_sd_en,
  input  logic                cfg_sd9,
  input  logic                cfg_sd10,
  input  logic                cfg_lbl_en,
  input  logic                cfg_tab_mode,
  input  logic                tab_load,
  input  logic [A_LBL_W-1:0]  tab_wdata,
  input  logic                tab_rd,
  output logic [A_LBL_W-1:0]  tab_rdata,
  input  logic                rx_pop,
  output logic [A_WORD_W-1:0] rx_data,
  output logic                rx_rdy,
  output logic                rx_rdy_n,
  output logic                rx_half,
  output logic                rx_half_n,
  output logic                rx_full,
  output logic                rx_full_n
);
  // Internal events, named for the checker
  logic lbl_hit, sd_ok, lbl_ok, word_accept, push_ok, pop_ok;

  a429_label_table #(.LBL_W(A_LBL_W), .LBL_N(LBL_N)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .access   (cfg_tab_mode),
    .load     (tab_load),
    .wdata    (tab_wdata),
    .rd       (tab_rd),
    .rdata    (tab_rdata),
    .label_in (f_label(word_in)),
    .hit      (lbl_hit)
  );

  a429_word_gate u_gate (
    .valid   (word_valid),
    .word    (word_in),
    .sd_en   (cfg_sd_en),
    .sd9     (cfg_sd9),
    .sd10    (cfg_sd10),
    .lbl_en  (cfg_lbl_en),
    .lbl_hit (lbl_hit),
    .sd_ok   (sd_ok),
    .lbl_ok  (lbl_ok),
    .accept  (word_accept)
  );

  a429_rx_fifo #(.W(A_WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (word_accept),
    .wdata     (word_in),
    .pop       (rx_pop),
    .rdata     (rx_data),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .not_empty (rx_rdy),
    .half      (rx_half),
    .full      (rx_full)
  );

  assign rx_rdy_n  = !rx_rdy;
  assign rx_half_n = !rx_half;
  assign rx_full_n = !rx_full;
endmodule

// File: rtl/a429_rx_filter_chk.sv
module a429_rx_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic [31:0] word_in,
  input logic        cfg_sd_en,
  input logic        cfg_sd9,
  input logic        cfg_sd10,
  input logic        rx_pop,
  input logic [31:0] rx_data,
  input logic        rx_rdy,
  input logic        rx_half,
  input logic        rx_full,
  input logic        word_accept,
  input logic        push_ok
);
  assert_sd_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_accept && cfg_sd_en) |-> (word_in[8] == cfg_sd9 && word_in[9] == cfg_sd10));

  assert_rdy_after_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> rx_rdy);

  assert_half_implies_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half |-> rx_rdy);

  assert_full_implies_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_half);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && word_accept && !rx_pop) |=> (rx_full && $stable(rx_data)));

  assert_reject_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_accept && !rx_pop) |=>
      ($stable(rx_rdy) && $stable(rx_half) && $stable(rx_full) && $stable(rx_data)));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_rdy && rx_pop && !word_accept) |=> !rx_rdy);
endmodule

bind a429_rx_filter a429_rx_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_valid  (word_valid),
  .word_in     (word_in),
  .cfg_sd_en   (cfg_sd_en),
  .cfg_sd9     (cfg_sd9),
  .cfg_sd10    (cfg_sd10),
  .rx_pop      (rx_pop),
  .rx_data     (rx_data),
  .rx_rdy      (rx_rdy),
  .rx_half     (rx_half),
  .rx_full     (rx_full),
  .word_accept (word_accept),
  .push_ok     (push_ok)
);

// File: tb/tb_a429_rx_filter.sv
module tb_a429_rx_filter;
  logic        clk = 0, rst_n = 0;
  logic        word_valid = 0;
  logic [31:0] word_in = '0;
  logic        cfg_sd_en = 0, cfg_sd9 = 0, cfg_sd10 = 0, cfg_lbl_en = 0, cfg_tab_mode = 0;
  logic        tab_load = 0, tab_rd = 0, rx_pop = 0;
  logic [7:0]  tab_wdata = '0;
  logic [7:0]  tab_rdata;
  logic [31:0] rx_data;
  logic        rx_rdy, rx_rdy_n, rx_half, rx_half_n, rx_full, rx_full_n;

  int checks = 0, errors = 0;
  logic [7:0] lbl [16];

  always #2 clk = ~clk;

  a429_rx_filter dut (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk); word_valid = 1; word_in = w;
    @(negedge clk); word_valid = 0;
  endtask

  task automatic pop1();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  function automatic logic exp_accept(input logic [31:0] w);
    logic hit = 0;
    for (int i = 0; i < 16; i++) if (lbl[i] == w[7:0]) hit = 1;
    if (cfg_sd_en && (w[8] != cfg_sd9 || w[9] != cfg_sd10)) return 0;
    if (cfg_lbl_en && !hit) return 0;
    return 1;
  endfunction

  // Send one word, check acceptance through rx_rdy, drain it if stored
  task automatic try_word(input string tag, input logic [31:0] w);
    logic e;
    e = exp_accept(w);
    send(w);
    check(tag, rx_rdy, e);
    if (rx_rdy) begin
      check("R10 data", rx_data, w);
      pop1();
      check("R5 rdy clears", {rx_rdy, rx_rdy_n}, 2'b01);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) lbl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 flags", {rx_rdy, rx_rdy_n, rx_half, rx_half_n, rx_full, rx_full_n}, 6'b010101);
    check("R11 table", tab_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R1/R2: bit 9/10 sweep, label test off
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      cfg_sd_en = k[4]; cfg_sd9 = k[3]; cfg_sd10 = k[2];
      try_word(k[4] ? "R1 sd match" : "R2 sd ignored",
               {20'hA5C3E, k[1], k[0], 2'b00, k[7:0]} | 32'(k[1:0] << 8));
    end
    cfg_sd_en = 0;

    // R4: normal-mode load ignored, then sequential load and readback
    @(negedge clk); tab_load = 1; tab_wdata = 8'h5A;
    @(negedge clk); tab_load = 0;
    @(negedge clk); cfg_tab_mode = 1;
    @(negedge clk); check("R4 normal load ignored", tab_rdata, 8'h00);
    for (int i = 0; i < 16; i++) begin
      lbl[i] = 8'(i * 37 + 11);
      @(negedge clk); tab_load = 1; tab_wdata = lbl[i];
      @(negedge clk); tab_load = 0;
    end
    @(negedge clk); cfg_tab_mode = 0;
    @(negedge clk); cfg_tab_mode = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); check("R4 readback", tab_rdata, lbl[i]);
      tab_rd = 1;
      @(negedge clk); tab_rd = 0;
    end
    @(negedge clk); check("R4 read pointer wraps", tab_rdata, lbl[0]);
    cfg_tab_mode = 0;

    // R3: all labels with recognition on
    cfg_lbl_en = 1;
    for (int l = 0; l < 256; l++) try_word("R3 label", {22'h2BEEF, 2'b11, 8'(l)});
    cfg_lbl_en = 0;
    try_word("R3 disabled passes", 32'h0000_03FF);

    // R9: both tests together
    cfg_lbl_en = 1; cfg_sd_en = 1; cfg_sd9 = 1; cfg_sd10 = 0;
    for (int k = 0; k < 16; k++) begin
      try_word("R9 both", {22'h11111, k[1], k[0], (k[3] ? lbl[k] : 8'(lbl[k] + 1))});
    end
    cfg_lbl_en = 0; cfg_sd_en = 0;

    // R5/R6/R7/R8: fill to 32 and beyond
    for (int i = 0; i < 33; i++) begin
      send(32'hC000_0000 + 32'(i));
      if (i == 0)  check("R5 rdy", {rx_rdy, rx_rdy_n}, 2'b10);
      if (i == 14) check("R6 half below", {rx_half, rx_half_n}, 2'b01);
      if (i == 15) check("R6 half at 16", {rx_half, rx_half_n}, 2'b10);
      if (i == 30) check("R7 not full at 31", {rx_full, rx_full_n}, 2'b01);
      if (i == 31) check("R7 full at 32", {rx_full, rx_full_n}, 2'b10);
      if (i == 32) check("R8 still full", {rx_full, rx_data}, {1'b1, 32'hC000_0000});
    end
    // R9 rejected word leaves FIFO intact
    cfg_sd_en = 1; cfg_sd9 = 1;
    send(32'h0000_0000);
    check("R9 reject keeps flags", {rx_rdy, rx_half, rx_full}, 3'b111);
    cfg_sd_en = 0;
    for (int i = 0; i < 32; i++) begin
      check("R8 R10 order", rx_data, 32'hC000_0000 + 32'(i));
      pop1();
      if (i == 16) check("R6 half drops at 15", rx_half, 1'b0);
      if (i == 0)  check("R7 full drops", rx_full, 1'b0);
    end
    check("R5 empty after drain", {rx_rdy, rx_rdy_n}, 2'b01);

    // R10 pop on empty is ignored
    pop1();
    check("R10 empty pop", rx_rdy, 1'b0);
    send(32'h1234_5678);
    check("R10 after empty pop", {rx_rdy, rx_data}, {1'b1, 32'h1234_5678});
    pop1();
    check("R10 drained", rx_rdy, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule